// File: doc/BRIEF.md
# Four-way write-through data cache controller

This block sits between a simple processor port and a simple memory port and caches data for a byte-addressable machine with a 24-bit address. It holds 8 KB in 64-bit blocks, arranged as 256 sets of four ways. Each block keeps a tag, a valid bit and a two-bit replacement mark. The mark names the block as the victim, the next victim, or neither. The processor issues one byte load or one byte store at a time. Loads that hit return from the cache. A load that misses fetches the whole block from memory in a single response, installs it, and returns the requested byte from that block.

Stores always go to memory, so a cached block always matches memory and no dirty state exists. A store that hits also patches the cached byte. A store that misses leaves the tag store alone. Only one request is ever outstanding, on either side.

Top module: `wt_cache`

## Requirements
- R1: After reset every block is invalid, `cpu_ready` is 1, `cpu_done` is 0 and `mem_valid` is 0. In every set way 0 carries the victim mark and way 1 carries the next-victim mark.
- R2: An address splits into an offset in bits [2:0], a set index in bits [10:3] and a tag in bits [23:11]. A load hits when a valid way of the indexed set holds the tag. A load hit returns the byte selected by the offset, with `cpu_done` high on the second clock edge after acceptance, and issues no memory request.
- R3: A load miss issues exactly one memory read (`mem_write` 0), at the block address with the offset bits zeroed. Byte k of `mem_fill_data` (bits 8k+7:8k) is the byte at block address plus k. The byte at the offset is returned and the block is installed, so a later load to that block hits.
- R4: On a load miss, the lowest-numbered invalid way of the set is filled if one exists.
- R5: On a load miss in a full set, the victim way is replaced. The filled way is then handled as a touch under R6.
- R6: Touching a way (a hit, or a fill) updates the marks. If the way was the victim, the old next victim becomes the victim, and the next-victim mark moves to the lowest-numbered way that is neither the new victim nor the touched way. If the way was the next victim, the next-victim mark moves to the lowest-numbered way that is neither the victim nor the touched way. Touching any other way leaves the marks unchanged.
- R7: Every store issues exactly one memory write carrying the full address and the byte. A store hit also updates the cached byte and touches the way.
- R8: A store miss changes neither tags, valid bits nor marks. A later load to that block still misses and returns the stored byte from memory.
- R9: Every set always has exactly one victim way and exactly one different next-victim way.
- R10: One request at a time. `cpu_ready` falls after acceptance and returns with `cpu_done`, which is a one-cycle pulse. A memory request holds its address and kind until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Controller idle, request accepted when valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_done` |
| mem_valid | output | 1 | Memory request present |
| mem_write | output | 1 | 1 = write-through store, 0 = block read |
| mem_addr | output | 24 | Byte address for writes, block address for reads |
| mem_wdata | output | 8 | Store byte to memory |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_fill | input | 1 | Block read data present |
| mem_fill_data | input | 64 | Refill block, byte k at bits 8k+7:8k |

## Verification
Directed sequences first fill one set way by way, to separate lowest-invalid filling from victim selection. They then bring a fifth tag into the full set and replay the first four, and the pattern of misses that follows exposes which way each mark pointed to. Store hits followed by loads tell byte patching apart from write-allocate, and store misses followed by loads show that the tag store was left alone. A long pseudo-random mix over three sets and six tags, with varying memory latency, is checked against a behavioural model of hits, misses, data and memory traffic. This mix reaches hit-on-victim, hit-on-next and hit-on-other cases in many orders.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MREQ, ST_MWAIT} wtc_state_e;
  // replacement mark codes held per block
  localparam logic [1:0] MK_NONE = 2'b00;
  localparam logic [1:0] MK_NEXT = 2'b01;
  localparam logic [1:0] MK_VICT = 2'b10;
endpackage

// File: rtl/wt_cache_match.sv
module wt_cache_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 13
) (
  input  logic [WAYS*TAG_W-1:0]    tags,
  input  logic [WAYS-1:0]          vld,
  input  logic [TAG_W-1:0]         tag,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  output logic                     any_inv,
  output logic [$clog2(WAYS)-1:0]  inv_way
);
  localparam int WAY_W = $clog2(WAYS);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    hit     = |eq;
    any_inv = ~&vld;
    hit_way = '0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w])  hit_way = WAY_W'(w);
      if (!vld[w]) inv_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wt_cache_repl.sv
module wt_cache_repl
  import wtc_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic [2*WAYS-1:0]        marks_in,
  input  logic [$clog2(WAYS)-1:0]  touch_way,
  output logic [$clog2(WAYS)-1:0]  vict_way,
  output logic [2*WAYS-1:0]        marks_out
);
  localparam int WAY_W = $clog2(WAYS);
  logic [WAY_W-1:0] nxt_way, new_v, new_n;

  function automatic logic [WAY_W-1:0] lowest_other(input logic [WAY_W-1:0] a,
                                                     input logic [WAY_W-1:0] b);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (WAY_W'(w) != a && WAY_W'(w) != b) r = WAY_W'(w);
    return r;
  endfunction

  always_comb begin
    vict_way = '0;
    nxt_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (marks_in[2*w +: 2] == MK_VICT) vict_way = WAY_W'(w);
      if (marks_in[2*w +: 2] == MK_NEXT) nxt_way  = WAY_W'(w);
    end
  end

  always_comb begin
    new_v = vict_way;
    new_n = nxt_way;
    if (touch_way == vict_way) begin
      new_v = nxt_way;
      new_n = lowest_other(nxt_way, touch_way);
    end else if (touch_way == nxt_way) begin
      new_n = lowest_other(vict_way, touch_way);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == new_v)      marks_out[2*w +: 2] = MK_VICT;
      else if (WAY_W'(w) == new_n) marks_out[2*w +: 2] = MK_NEXT;
      else                         marks_out[2*w +: 2] = MK_NONE;
    end
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SETS      = 256,
  parameter int WAYS      = 4,
  parameter int BLK_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [7:0]             cpu_wdata,
  output logic                   cpu_ready,
  output logic                   cpu_done,
  output logic [7:0]             cpu_rdata,
  output logic                   mem_valid,
  output logic                   mem_write,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic                   mem_ready,
  input  logic                   mem_fill,
  input  logic [BLK_BYTES*8-1:0] mem_fill_data
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int BLK_W = BLK_BYTES * 8;
  localparam logic [2*WAYS-1:0] MRK_RESET = (2*WAYS)'({MK_NEXT, MK_VICT});

  // storage
  logic [TAG_W-1:0]  tag_a  [SETS][WAYS];
  logic [BLK_W-1:0]  data_a [SETS][WAYS];
  logic [WAYS-1:0]   vld_a  [SETS];
  logic [2*WAYS-1:0] mrk_a  [SETS];

  // request registers
  wtc_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [7:0]        wd_q, wd_d;
  logic [WAY_W-1:0]  fway_q, fway_d;
  logic              done_q, done_d;
  logic [7:0]        rdata_q, rdata_d;

  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic [OFF_W+2:0]      sel;
  logic [WAYS*TAG_W-1:0] cur_tags;
  logic [2*WAYS-1:0]     cur_mrk, mrk_new;
  logic [WAY_W-1:0]      hit_way, inv_way, vict_way, touch_way;
  logic                  hit, any_inv;
  logic [BLK_W-1:0]      hit_blk;
  logic                  fill_we, byte_we, mrk_we;

  assign idx     = addr_q[OFF_W +: IDX_W];
  assign tag     = addr_q[ADDR_W-1 -: TAG_W];
  assign sel     = {addr_q[OFF_W-1:0], 3'b000};
  assign cur_mrk = mrk_a[idx];
  assign hit_blk = data_a[idx][hit_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign cur_tags[w*TAG_W +: TAG_W] = tag_a[idx][w];
  end

  wt_cache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags(cur_tags), .vld(vld_a[idx]), .tag(tag),
    .hit(hit), .hit_way(hit_way), .any_inv(any_inv), .inv_way(inv_way)
  );

  wt_cache_repl #(.WAYS(WAYS)) u_repl (
    .marks_in(cur_mrk), .touch_way(touch_way),
    .vict_way(vict_way), .marks_out(mrk_new)
  );

  // next-state and output decode
  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    wr_d      = wr_q;
    wd_d      = wd_q;
    fway_d    = fway_q;
    done_d    = 1'b0;
    rdata_d   = rdata_q;
    cpu_ready = 1'b0;
    mem_valid = 1'b0;
    mem_write = wr_q;
    mem_addr  = wr_q ? addr_q : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    mem_wdata = wd_q;
    fill_we   = 1'b0;
    byte_we   = 1'b0;
    mrk_we    = 1'b0;
    touch_way = hit_way;
    unique case (st_q)
      ST_IDLE: begin
        cpu_ready = 1'b1;
        if (cpu_valid) begin
          st_d   = ST_LOOK;
          addr_d = cpu_addr;
          wr_d   = cpu_write;
          wd_d   = cpu_wdata;
        end
      end
      ST_LOOK: begin
        fway_d  = any_inv ? inv_way : vict_way;
        mrk_we  = hit;
        byte_we = hit && wr_q;
        if (hit && !wr_q) begin
          done_d  = 1'b1;
          rdata_d = hit_blk[sel +: 8];
          st_d    = ST_IDLE;
        end else begin
          st_d = ST_MREQ;
        end
      end
      ST_MREQ: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          if (wr_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_MWAIT;
          end
        end
      end
      ST_MWAIT: begin
        touch_way = fway_q;
        if (mem_fill) begin
          fill_we = 1'b1;
          mrk_we  = 1'b1;
          done_d  = 1'b1;
          rdata_d = mem_fill_data[sel +: 8];
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      fway_q  <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      wr_q    <= wr_d;
      wd_q    <= wd_d;
      fway_q  <= fway_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  // valid bits and replacement marks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_a[s] <= '0;
        mrk_a[s] <= MRK_RESET;
      end
    end else begin
      if (fill_we) vld_a[idx][fway_q] <= 1'b1;
      if (mrk_we)  mrk_a[idx] <= mrk_new;
    end
  end

  // tag and data arrays, no reset
  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_a[idx][fway_q]  <= tag;
      data_a[idx][fway_q] <= mem_fill_data;
    end else if (byte_we) begin
      data_a[idx][hit_way][sel +: 8] <= wd_q;
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk
  import wtc_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int ADDR_W    = 24,
  parameter int BLK_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              mem_valid,
  input logic              mem_write,
  input logic              mem_ready,
  input logic              mem_fill,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hit,
  input logic              wr_q,
  input logic [2*WAYS-1:0] cur_mrk,
  input wtc_state_e        st_q
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  logic [WAYS-1:0] vflag, nflag;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      vflag[w] = cur_mrk[2*w +: 2] == MK_VICT;
      nflag[w] = cur_mrk[2*w +: 2] == MK_NEXT;
    end
  end

  p_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vflag) == 1 && $countones(nflag) == 1 && (vflag & nflag) == '0);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready |=> !cpu_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  p_load_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_LOOK && hit && !wr_q |=> cpu_done && !mem_valid);

  p_miss_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_LOOK && !hit && !wr_q |=> mem_valid && !mem_write && mem_addr[OFF_W-1:0] == '0);

  p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_MWAIT && mem_fill |=> cpu_done && cpu_ready);

  p_store_wt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_LOOK && wr_q |=> mem_valid && mem_write);
endmodule

bind wt_cache wt_cache_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_ready(mem_ready), .mem_fill(mem_fill), .mem_addr(mem_addr),
  .hit(hit), .wr_q(wr_q), .cur_mrk(cur_mrk), .st_q(st_q)
);

// File: tb/tb_wt_cache.sv
`timescale 1ns/1ps
module tb_wt_cache;
  localparam int ADDR_W = 24;

  logic        clk, rst_n;
  logic        cpu_valid, cpu_write, cpu_ready, cpu_done;
  logic [23:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        mem_valid, mem_write, mem_ready, mem_fill;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [63:0] mem_fill_data;

  wt_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_fill(mem_fill), .mem_fill_data(mem_fill_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks, fails;
  bit busy;
  int unsigned lcg;
  byte unsigned memw [int];
  int rd_cnt, wr_cnt;
  logic [23:0] last_rd_addr, last_wr_addr;
  logic [7:0]  last_wr_data;

  // behavioural model: per set an array of tags, a victim index and a next index
  int m_tag [256][4];
  bit m_vld [256][4];
  int m_vic [256];
  int m_nxt [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic byte unsigned mem_rd(input int a);
    if (memw.exists(a)) return memw[a];
    return 8'((a * 37) ^ (a >> 7) ^ 8'h5A);
  endfunction

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return int'((lcg >> 16) & 16'h7fff);
  endfunction

  function automatic int pick_other(input int a, input int b);
    for (int w = 0; w < 4; w++) if (w != a && w != b) return w;
    return 0;
  endfunction

  function automatic void touch(input int s, input int h);
    if (h == m_vic[s]) begin
      m_vic[s] = m_nxt[s];
      m_nxt[s] = pick_other(m_vic[s], h);
    end else if (h == m_nxt[s]) begin
      m_nxt[s] = pick_other(m_vic[s], h);
    end
  endfunction

  // memory responder
  initial begin
    int wait_n, fill_n;
    logic [23:0] fa;
    wait_n = 0; fill_n = -1; fa = '0;
    mem_ready = 1'b0; mem_fill = 1'b0; mem_fill_data = '0;
    rd_cnt = 0; wr_cnt = 0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      mem_fill  = 1'b0;
      if (fill_n == 0) begin
        mem_fill = 1'b1;
        for (int b = 0; b < 8; b++) mem_fill_data[b*8 +: 8] = mem_rd(int'(fa) + b);
        fill_n = -1;
      end else if (fill_n > 0) begin
        fill_n--;
      end else if (mem_valid) begin
        if (wait_n > 0) wait_n--;
        else begin
          mem_ready = 1'b1;
          if (mem_write) begin
            wr_cnt++;
            last_wr_addr = mem_addr;
            last_wr_data = mem_wdata;
            memw[int'(mem_addr)] = mem_wdata;
          end else begin
            rd_cnt++;
            last_rd_addr = mem_addr;
            fa = mem_addr;
            fill_n = rnd() % 3;
          end
          wait_n = rnd() % 3;
        end
      end
    end
  end

  // every-clock idle comparison
  always @(posedge clk) begin
    #1;
    if (rst_n && !busy)
      chk(cpu_ready && !cpu_done && !mem_valid, "R10", "idle outputs",
          {cpu_ready, cpu_done, mem_valid}, 3'b100);
  end

  task automatic access(input bit we, input logic [23:0] a, input byte unsigned wd,
                        input string req);
    int s, t, hw, prd, pwr, n, way;
    byte unsigned exp_d;
    s = int'(a[10:3]); t = int'(a[23:11]); hw = -1; n = 0;
    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
    @(negedge clk);
    busy = 1'b1;
    chk(cpu_ready == 1'b1, "R10", "ready before request", cpu_ready, 1);
    prd = rd_cnt; pwr = wr_cnt;
    cpu_valid = 1'b1; cpu_write = we; cpu_addr = a; cpu_wdata = wd;
    @(posedge clk);
    do begin
      @(negedge clk);
      cpu_valid = 1'b0;
      n++;
    end while (!cpu_done && n < 200);
    chk(cpu_done, req, "completion", cpu_done, 1);
    if (!we) begin
      exp_d = mem_rd(int'(a));
      chk(cpu_rdata == exp_d, req, "load data", cpu_rdata, exp_d);
      chk(rd_cnt - prd == ((hw >= 0) ? 0 : 1), req, "memory reads", rd_cnt - prd, (hw >= 0) ? 0 : 1);
      chk(wr_cnt == pwr, req, "no write on load", wr_cnt - pwr, 0);
      if (hw >= 0) begin
        chk(n == 2, "R2", "hit latency", n, 2);
        touch(s, hw);
      end else begin
        chk(last_rd_addr == {a[23:3], 3'b000}, "R3", "refill address", last_rd_addr, {a[23:3], 3'b000});
        way = m_vic[s];
        for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) way = w;
        m_vld[s][way] = 1'b1;
        m_tag[s][way] = t;
        touch(s, way);
      end
    end else begin
      chk(wr_cnt - pwr == 1, "R7", "one memory write", wr_cnt - pwr, 1);
      chk(rd_cnt == prd, "R8", "no read on store", rd_cnt - prd, 0);
      chk(last_wr_addr == a && last_wr_data == wd, "R7", "write address/data",
          {last_wr_addr, last_wr_data}, {a, wd});
      if (hw >= 0) touch(s, hw);
    end
    busy = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; busy = 1'b1; lcg = 32'h1234_5678;
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    for (int s = 0; s < 256; s++) begin
      m_vic[s] = 0; m_nxt[s] = 1;
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = 0; end
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpu_ready == 1'b1 && cpu_done == 1'b0 && mem_valid == 1'b0, "R1", "reset outputs",
        {cpu_ready, cpu_done, mem_valid}, 3'b100);
    @(posedge clk); #1 rst_n = 1'b1;
    busy = 1'b0;

    // R1/R3: first access misses, refill then hit (R2)
    access(1'b0, 24'h000205, 8'h00, "R1");
    access(1'b0, 24'h000203, 8'h00, "R2");
    access(1'b0, 24'h000207, 8'h00, "R2");

    // R4: fill set 5 with four tags (stride 0x800 keeps the set)
    for (int k = 0; k < 4; k++) access(1'b0, 24'h000028 + 24'(k * 'h800), 8'h00, "R4");
    for (int k = 0; k < 4; k++) access(1'b0, 24'h00002C + 24'(k * 'h800), 8'h00, "R4");

    // R5: fifth tag evicts the victim, replay shows which ways survived
    access(1'b0, 24'h000028 + 24'(4 * 'h800), 8'h00, "R5");
    for (int k = 0; k < 5; k++) access(1'b0, 24'h000029 + 24'(k * 'h800), 8'h00, "R5");

    // R6: hits on victim, next and other ways in a fresh set
    for (int k = 0; k < 4; k++) access(1'b0, 24'h000100 + 24'(k * 'h800), 8'h00, "R6");
    access(1'b0, 24'h000100, 8'h00, "R6");
    access(1'b0, 24'h000900, 8'h00, "R6");
    access(1'b0, 24'h001900, 8'h00, "R6");
    access(1'b0, 24'h002100, 8'h00, "R6");
    for (int k = 0; k < 6; k++) access(1'b0, 24'h000101 + 24'(k * 'h800), 8'h00, "R6");

    // R7: store hit patches the block, write goes through
    access(1'b1, 24'h000204, 8'hC3, "R7");
    access(1'b0, 24'h000204, 8'h00, "R7");

    // R8: store miss does not allocate
    access(1'b1, 24'h7F0010, 8'h3C, "R8");
    access(1'b0, 24'h7F0010, 8'h00, "R8");

    // mixed traffic over three sets and six tags (R5, R6, R7, R8)
    for (int i = 0; i < 400; i++) begin
      int sidx, tg, off;
      bit we;
      sidx = rnd() % 3;
      tg   = rnd() % 6;
      off  = rnd() % 8;
      we   = (rnd() % 4) == 0;
      access(we, 24'((tg << 11) | ((sidx == 0 ? 3 : sidx == 1 ? 5 : 200) << 3) | off),
             8'(rnd()), "R6");
    end

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule